// File: doc/BRIEF.md
# Dual-Compare Buffered PWM Timer

The block is a 16-bit up-counter with three compare registers and one PWM output. One compare register pulls the output to a programmed level and a second one pulls it back. The third compare register can end the period by clearing the counter. A fourth register can act as a shadow copy of the first edge register. Its value is moved into that register only at a period boundary, so the duty cycle of a running waveform can be changed without a glitch.

An external trigger pin, with a selectable active edge, can also restart the period and perform the shadow transfer. A host writes the registers and the control field through a simple write port. A separate enable input gates counting.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset the counter and all registers are zero and `pwm_o` is 1, the inverse of the reset polarity bit.
- R2: The counter advances by one on each clock where `cnt_en_i` is 1 and holds its value when `cnt_en_i` is 0, unless it is cleared.
- R3: With the polarity bit (control bit 0) at 0, a counter match with the B register drives `pwm_o` to 0 on the next clock, and a match with the C register drives it to 1.
- R4: With the polarity bit at 1, a B match drives `pwm_o` to 1 and a C match drives it to 0.
- R5: When B and C match in the same cycle, the C match decides the level.
- R6: With the clear-enable bit (control bit 2) at 1, a match with the A register sets the counter to 0 on the next clock, so the period is A+1 clocks.
- R7: With the clear-enable bit at 0, an A match does not clear the counter. The counter keeps counting and wraps from 0xFFFF to 0.
- R8: With the shadow-enable bit (control bit 1) at 1, the D register is copied into B on an A match or on a trigger event. A write to D does not change the output before that transfer.
- R9: With the shadow-enable bit at 0, B changes only through a write, and the write takes effect on the clock that accepts it.
- R10: The trigger edge field (control bits 4:3) selects the active edge: 00 none, 01 rising, 10 falling, 11 both. The trigger is synchronised by two flops, and the counter reads 0 after the third clock edge that follows an active trigger edge.
- R11: The write port selects A, B, C, D or the control field with addresses 0, 1, 2, 3 and 4. Writes to other addresses are ignored. An edge that the trigger edge field does not select has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register address: 0 A, 1 B, 2 C, 3 D, 4 control |
| wr_data_i | input | 16 | Write data; the control field uses bits 4:0 |
| cnt_en_i | input | 1 | Count enable |
| trig_i | input | 1 | External restart trigger, asynchronous |
| pwm_o | output | 1 | PWM output |

## Verification
A compare match is seen in the cycle the counter holds the matching value, and `pwm_o` changes on the following clock. A clear also takes effect on the following clock. A trigger edge reaches the counter on the third clock, so with B=2 the output falls at the sixth sampled cycle after the trigger toggles. The bench samples on falling clock edges. It either counts low cycles over whole 100-clock windows, which gives a result that does not depend on phase, or it locks onto an observed output edge and samples a fixed number of cycles after it. An immediate write to B then shows two clocks after the write, while a shadowed write to D leaves the output unchanged at that point.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

  typedef enum logic [2:0] {
    SEL_A    = 3'd0,
    SEL_B    = 3'd1,
    SEL_C    = 3'd2,
    SEL_D    = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  // bit 0 polarity, 1 shadow enable, 2 clear on A, 4:3 trigger edge
  typedef struct packed {
    logic [1:0] trig_edge;
    logic       clr_on_a;
    logic       shadow_en;
    logic       b_level;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int NUM_CMP = 3;
  localparam int CMP_A   = 0;
  localparam int CMP_B   = 1;
  localparam int CMP_C   = 2;

endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic [CNT_W-1:0] cmp_c_o,
  output logic [CNT_W-1:0] cmp_d_o,
  output ctrl_t            ctrl_o
);

  logic wr_a, wr_b, wr_c, wr_d, wr_ctrl;

  always_comb begin
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    wr_c    = 1'b0;
    wr_d    = 1'b0;
    wr_ctrl = 1'b0;
    if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_A:    wr_a    = 1'b1;
        SEL_B:    wr_b    = 1'b1;
        SEL_C:    wr_c    = 1'b1;
        SEL_D:    wr_d    = 1'b1;
        SEL_CTRL: wr_ctrl = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_a_o <= '0;
      cmp_c_o <= '0;
      cmp_d_o <= '0;
      ctrl_o  <= '0;
    end else begin
      if (wr_a)    cmp_a_o <= wr_data_i;
      if (wr_c)    cmp_c_o <= wr_data_i;
      if (wr_d)    cmp_d_o <= wr_data_i;
      if (wr_ctrl) ctrl_o  <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  // host write to B has priority over the shadow transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_b_o <= '0;
    end else if (wr_b) begin
      cmp_b_o <= wr_data_i;
    end else if (xfer_i && ctrl_o.shadow_en) begin
      cmp_b_o <= cmp_d_o;
    end
  end

endmodule

// File: rtl/cpwm_trig.sv
`timescale 1ns/1ps
module cpwm_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [1:0] edge_sel_i,
  output logic       evt_o
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q[s] <= 1'b0;
      end else if (s == 0) begin
        pipe_q[s] <= trig_i;
      end else begin
        pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  logic synced, prev, rise, fall;

  assign synced = pipe_q[SYNC_STAGES-1];
  assign prev   = pipe_q[SYNC_STAGES];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;
  assign evt_o  = (rise & edge_sel_i[0]) | (fall & edge_sel_i[1]);

endmodule

// File: rtl/cpwm_counter.sv
`timescale 1ns/1ps
module cpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (en_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/cpwm_compare.sv
`timescale 1ns/1ps
module cpwm_compare
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] ref_i,
  output logic [NUM_CMP-1:0]            match_o
);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign match_o[k] = (cnt_i == ref_i[k]);
  end

endmodule

// File: rtl/cpwm_outstage.sv
`timescale 1ns/1ps
module cpwm_outstage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_b_i,
  input  logic hit_c_i,
  input  logic b_level_i,
  output logic pwm_o
);

  // reset level is the inverse of the reset polarity (0)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o <= 1'b1;
    end else if (hit_c_i) begin
      pwm_o <= ~b_level_i;
    end else if (hit_b_i) begin
      pwm_o <= b_level_i;
    end
  end

endmodule

// File: rtl/cmp_pwm_timer.sv
`timescale 1ns/1ps
module cmp_pwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             cnt_en_i,
  input  logic             trig_i,
  output logic             pwm_o
);

  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              cmp_a, cmp_b, cmp_c, cmp_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] refs;
  logic [NUM_CMP-1:0]            match;
  ctrl_t                         ctrl;
  logic                          trig_evt;
  logic                          cnt_clr;
  logic                          xfer;

  assign refs[CMP_A] = cmp_a;
  assign refs[CMP_B] = cmp_b;
  assign refs[CMP_C] = cmp_c;

  assign cnt_clr = (match[CMP_A] & ctrl.clr_on_a) | trig_evt;
  assign xfer    = match[CMP_A] | trig_evt;

  cpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .xfer_i    (xfer),
    .cmp_a_o   (cmp_a),
    .cmp_b_o   (cmp_b),
    .cmp_c_o   (cmp_c),
    .cmp_d_o   (cmp_d),
    .ctrl_o    (ctrl)
  );

  cpwm_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .edge_sel_i (ctrl.trig_edge),
    .evt_o      (trig_evt)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i   (cnt),
    .ref_i   (refs),
    .match_o (match)
  );

  cpwm_outstage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_b_i   (match[CMP_B]),
    .hit_c_i   (match[CMP_C]),
    .b_level_i (ctrl.b_level),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/cmp_pwm_timer_chk.sv
`timescale 1ns/1ps
module cmp_pwm_timer_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [2:0]         wr_sel_i,
  input logic               cnt_en_i,
  input logic [CNT_W-1:0]   cnt,
  input logic [NUM_CMP-1:0] match,
  input ctrl_t              ctrl,
  input logic               trig_evt,
  input logic [CNT_W-1:0]   cmp_b,
  input logic [CNT_W-1:0]   cmp_d,
  input logic               pwm_o
);

  logic wr_b;
  assign wr_b = wr_en_i && (wr_sel_i == 3'd1);

  AST_RESET_LEVEL: assert property (@(posedge clk_i)
    !rst_ni |=> (pwm_o && cnt == '0)); // R1

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !trig_evt && !(match[CMP_A] && ctrl.clr_on_a))
      |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !trig_evt && !(match[CMP_A] && ctrl.clr_on_a)) |=> $stable(cnt)); // R2

  AST_B_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match[CMP_B] && !match[CMP_C]) |=> pwm_o == $past(ctrl.b_level)); // R3

  AST_C_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[CMP_C] |=> pwm_o == !$past(ctrl.b_level)); // R5

  AST_A_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match[CMP_A] && ctrl.clr_on_a) |=> cnt == '0); // R6

  AST_A_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match[CMP_A] && !ctrl.clr_on_a && !trig_evt && cnt_en_i)
      |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R7

  AST_SHADOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.shadow_en && (match[CMP_A] || trig_evt) && !wr_b) |=> cmp_b == $past(cmp_d)); // R8

  AST_B_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.shadow_en && !wr_b) |=> $stable(cmp_b)); // R9

  AST_TRIG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt |=> cnt == '0); // R10

  AST_TRIG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.trig_edge == 2'b00) |-> !trig_evt); // R11

endmodule

bind cmp_pwm_timer cmp_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .cnt_en_i (cnt_en_i),
  .cnt      (cnt),
  .match    (match),
  .ctrl     (ctrl),
  .trig_evt (trig_evt),
  .cmp_b    (cmp_b),
  .cmp_d    (cmp_d),
  .pwm_o    (pwm_o)
);

// File: tb/cmp_pwm_timer_bench.sv
`timescale 1ns/1ps
module cmp_pwm_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        cnt_en;
  logic        trig;
  logic        pwm;

  always #10 clk = ~clk;

  cmp_pwm_timer u_cmp_pwm_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .cnt_en_i  (cnt_en),
    .trig_i    (trig),
    .pwm_o     (pwm)
  );

  typedef struct {
    string tag;
    int    exp;
  } exp_t;

  exp_t sb_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // control field: {edge[1:0], clr_on_a, shadow_en, polarity}
  function automatic logic [15:0] ctrl_word(int edge_sel, bit clr, bit shd, bit pol);
    return 16'((edge_sel << 3) | (int'(clr) << 2) | (int'(shd) << 1) | int'(pol));
  endfunction

  task automatic push_exp(string tag, int e);
    exp_t it;
    it.tag = tag;
    it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic observe(int act);
    exp_t it;
    n_run++;
    if (sb_q.size() == 0) begin
      n_fail++;
      $display("FAIL scoreboard empty: got %0d expected none", act);
    end else begin
      it = sb_q.pop_front();
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: got %0d expected %0d", it.tag, act, it.exp);
      end
    end
  endtask

  task automatic do_reset(bit trig_lvl);
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = '0;
    wr_data = '0;
    cnt_en  = 1'b0;
    trig    = trig_lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] data);
    wr_sel  = sel;
    wr_data = data;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic setup(int a, int b, int c, int d, logic [15:0] ctl);
    wr(3'd0, 16'(a));
    wr(3'd1, 16'(b));
    wr(3'd2, 16'(c));
    wr(3'd3, 16'(d));
    wr(3'd5, 16'hFFFF); // unmapped address, must be ignored (R11)
    wr(3'd4, ctl);
  endtask

  task automatic count_low(int n, output int lo);
    lo = 0;
    repeat (n) begin
      @(negedge clk);
      if (!pwm) lo++;
    end
  endtask

  task automatic duty_case(string tag, int b, int c, bit clr, bit pol, int exp_low);
    int lo;
    do_reset(1'b0);
    setup(9, b, c, 0, ctrl_word(0, clr, 1'b0, pol));
    cnt_en = 1'b1;
    repeat (30) @(negedge clk);
    push_exp(tag, exp_low);
    count_low(100, lo);
    observe(lo);
  endtask

  task automatic update_case(bit shadowed);
    int lo;
    do_reset(1'b0);
    setup(9, 3, 7, 3, ctrl_word(0, 1'b1, shadowed, 1'b0));
    cnt_en = 1'b1;
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    // counter is at 8 here
    wr(shadowed ? 3'd3 : 3'd1, 16'd9);
    @(negedge clk);
    push_exp(shadowed ? "R8 shadow write held until A match" : "R9 direct B write immediate",
             shadowed ? 1 : 0);
    observe(int'(pwm));
    repeat (20) @(negedge clk);
    push_exp(shadowed ? "R8 duty after transfer" : "R9 duty after write", 80);
    count_low(100, lo);
    observe(lo);
  endtask

  task automatic trig_case(int edge_sel, bit rising);
    int  lat;
    bit  hit;
    bit  active;
    string tag;
    do_reset(!rising);
    setup(0, 2, 5, 0, ctrl_word(edge_sel, 1'b0, 1'b0, 1'b0));
    cnt_en = 1'b1;
    repeat (20) @(negedge clk);
    trig = rising;
    lat  = 0;
    hit  = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!pwm && !hit) begin
        hit = 1;
        lat = i;
      end
    end
    active = rising ? edge_sel[0] : edge_sel[1];
    tag = $sformatf("%s trigger sel=%0d %s edge", active ? "R10" : "R11",
                    edge_sel, rising ? "rising" : "falling");
    push_exp(tag, active ? 6 : 0);
    observe(lat);
  endtask

  initial begin
    int lo;
    do_reset(1'b0);
    push_exp("R1 reset output level", 1);
    observe(int'(pwm));

    duty_case("R3 R6 polarity 0 low cycles", 3, 7, 1'b1, 1'b0, 40);
    duty_case("R4 polarity 1 low cycles",    3, 7, 1'b1, 1'b1, 60);
    duty_case("R5 C wins, polarity 0",       5, 5, 1'b1, 1'b0, 0);
    duty_case("R5 C wins, polarity 1",       5, 5, 1'b1, 1'b1, 100);
    duty_case("R7 no clear on A",            3, 7, 1'b0, 1'b0, 0);

    // R2: counting only while enabled
    do_reset(1'b0);
    setup(9, 2, 5, 0, ctrl_word(0, 1'b1, 1'b0, 1'b0));
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
    push_exp("R2 held at 1, no B match", 0);
    count_low(50, lo);
    observe(lo);
    cnt_en = 1'b1;
    repeat (2) @(negedge clk);
    cnt_en = 1'b0;
    push_exp("R2 held after passing B", 50);
    count_low(50, lo);
    observe(lo);

    update_case(1'b0);
    update_case(1'b1);

    for (int s = 0; s < 4; s++) begin
      trig_case(s, 1'b1);
      trig_case(s, 1'b0);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule